// File: doc/BRIEF.md
# Power-Fail DRAM Self-Refresh Sequencer

This block takes over the control pins of a DDR4 channel when a power-loss trigger arrives. Its job is to leave a non-volatile memory module in self-refresh with its reset asserted before power is gone. While the block is idle, software loads three wait values: the refresh recovery time, the precharge time, and the self-refresh entry time. During this idle period the normal memory controller drives the pins through the block's output multiplexer.

A trigger switches pin ownership to the sequencer and starts the steps at once, with no initial delay. The steps run in this order:

1. A deselect, followed by the refresh recovery wait.
2. A precharge of all banks, followed by the precharge wait.
3. A self-refresh entry, followed by the entry wait.
4. A final state that drives reset low and raises a done flag.

The block stays in that final state until it is reset. While the sequence runs, it ignores further triggers and drops any configuration writes.

Top module: `pf_sr_seq`

## Requirements
- R1: After reset the block is idle, mux_sel_o and done_o are 0, and the three wait registers hold 0.
- R2: While idle, mem_cs_n_o, mem_cke_o, mem_reset_n_o and mem_cmd_o equal the nrm_* inputs in the same cycle.
- R3: Step one starts on the cycle after the clock edge that samples trigger_i high while idle. It drives cmd 2'b00 (deselect), every chip-select bit high, every CKE bit high and reset_n high. It lasts tRFC+1 cycles.
- R4: Step two drives cmd 2'b01 (precharge-all), each two-bit chip-select pair at code 2'b00, every CKE bit high and reset_n high. It lasts tRP+1 cycles.
- R5: Step three drives cmd 2'b10 (self-refresh entry), all chip selects low, all CKE low and reset_n high. It lasts tCKSRE+1 cycles.
- R6: After step three the block drives all chip selects high, all CKE low, reset_n low and cmd 2'b00, with done_o high. It holds these values until reset.
- R7: A trigger that arrives while the sequence is running or done has no effect on the outputs or on the step timing.
- R8: A configuration write (cfg_we_i) selects its target with cfg_sel_i: 0 is tRFC, 1 is tRP, 2 is tCKSRE, and 3 writes nothing. The write is accepted only while idle. A write made after the trigger is discarded, and the run in progress keeps the old values.
- R9: A wait value of zero makes its step last exactly one cycle.
- R10: mux_sel_o rises together with step one and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Wait register select (0 tRFC, 1 tRP, 2 tCKSRE) |
| cfg_data_i | input | 16 | Wait value in cycles |
| trigger_i | input | 1 | Power-loss trigger |
| nrm_cs_n_i | input | 4 | Chip selects from the normal controller |
| nrm_cke_i | input | 2 | CKE from the normal controller |
| nrm_reset_n_i | input | 1 | RESET_n from the normal controller |
| nrm_cmd_i | input | 2 | Command from the normal controller |
| mem_cs_n_o | output | 4 | Chip selects to the memory |
| mem_cke_o | output | 2 | CKE to the memory |
| mem_reset_n_o | output | 1 | RESET_n to the memory |
| mem_cmd_o | output | 2 | Command to the memory |
| mux_sel_o | output | 1 | High while the sequencer owns the pins |
| done_o | output | 1 | Sequence complete |

## Verification
In idle, the pin outputs follow the normal inputs combinationally, so they are compared in the same cycle as those inputs. Step one is due one edge after the trigger is sampled. Each step then lasts exactly its wait value plus one cycle, and done_o rises one cycle after the last self-refresh entry cycle.

The bench keeps to this timing with a behavioural model. On the trigger edge it expands the shadowed wait values into a queue of per-cycle pin patterns, pops one entry per edge, and compares the outputs against it at every falling edge. Step-length counters confirm that writes and triggers made during a run do not change the timing.

// File: rtl/pf_sr_pkg.sv
package pf_sr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DES,
    ST_PREA,
    ST_SRE,
    ST_DONE
  } step_e;

  localparam logic [1:0] CMD_DES  = 2'b00;
  localparam logic [1:0] CMD_PREA = 2'b01;
  localparam logic [1:0] CMD_SRE  = 2'b10;

  localparam logic [1:0] SEL_TRFC   = 2'd0;
  localparam logic [1:0] SEL_TRP    = 2'd1;
  localparam logic [1:0] SEL_TCKSRE = 2'd2;

  localparam logic [1:0] CS_PAIR_ACTIVE = 2'b00;
  localparam logic [1:0] CS_PAIR_IDLE   = 2'b11;
endpackage

// File: rtl/pf_sr_cfg.sv
module pf_sr_cfg #(
  parameter int TRFC_W   = 16,
  parameter int TRP_W    = 8,
  parameter int TCKSRE_W = 8,
  parameter int DATA_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                idle_i,
  input  logic                we_i,
  input  logic [1:0]          sel_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [TRFC_W-1:0]   trfc_o,
  output logic [TRP_W-1:0]    trp_o,
  output logic [TCKSRE_W-1:0] tcksre_o
);
  import pf_sr_pkg::*;

  logic wr_ok;
  assign wr_ok = we_i && idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trfc_o   <= '0;
      trp_o    <= '0;
      tcksre_o <= '0;
    end else if (wr_ok) begin
      case (sel_i)
        SEL_TRFC:   trfc_o   <= data_i[TRFC_W-1:0];
        SEL_TRP:    trp_o    <= data_i[TRP_W-1:0];
        SEL_TCKSRE: tcksre_o <= data_i[TCKSRE_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pf_sr_fsm.sv
module pf_sr_fsm #(
  parameter int TRFC_W   = 16,
  parameter int TRP_W    = 8,
  parameter int TCKSRE_W = 8,
  parameter int CNT_W    = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  trigger_i,
  input  logic [TRFC_W-1:0]     trfc_i,
  input  logic [TRP_W-1:0]      trp_i,
  input  logic [TCKSRE_W-1:0]   tcksre_i,
  output pf_sr_pkg::step_e      step_o
);
  import pf_sr_pkg::*;

  step_e             step_q, step_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    step_d = step_q;
    cnt_d  = cnt_q;
    unique case (step_q)
      ST_IDLE: if (trigger_i) begin
        step_d = ST_DES;
        cnt_d  = CNT_W'(trfc_i);
      end
      ST_DES: if (cnt_zero) begin
        step_d = ST_PREA;
        cnt_d  = CNT_W'(trp_i);
      end else cnt_d = cnt_q - 1'b1;
      ST_PREA: if (cnt_zero) begin
        step_d = ST_SRE;
        cnt_d  = CNT_W'(tcksre_i);
      end else cnt_d = cnt_q - 1'b1;
      ST_SRE: if (cnt_zero) step_d = ST_DONE;
              else cnt_d = cnt_q - 1'b1;
      ST_DONE: ;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      cnt_q  <= '0;
    end else begin
      step_q <= step_d;
      cnt_q  <= cnt_d;
    end
  end

  assign step_o = step_q;
endmodule

// File: rtl/pf_sr_pinmux.sv
module pf_sr_pinmux #(
  parameter int CS_PAIRS = 2,
  parameter int CKE_W    = 2,
  localparam int CS_W    = 2 * CS_PAIRS
) (
  input  pf_sr_pkg::step_e  step_i,
  input  logic [CS_W-1:0]   nrm_cs_n_i,
  input  logic [CKE_W-1:0]  nrm_cke_i,
  input  logic              nrm_reset_n_i,
  input  logic [1:0]        nrm_cmd_i,
  output logic [CS_W-1:0]   mem_cs_n_o,
  output logic [CKE_W-1:0]  mem_cke_o,
  output logic              mem_reset_n_o,
  output logic [1:0]        mem_cmd_o,
  output logic              mux_sel_o,
  output logic              done_o
);
  import pf_sr_pkg::*;

  logic             cs_act;
  logic [CS_W-1:0]  seq_cs_n;
  logic [CKE_W-1:0] seq_cke;
  logic             seq_rst_n;
  logic [1:0]       seq_cmd;

  assign mux_sel_o = (step_i != ST_IDLE);
  assign done_o    = (step_i == ST_DONE);
  assign cs_act    = (step_i == ST_PREA) || (step_i == ST_SRE);

  for (genvar p = 0; p < CS_PAIRS; p++) begin : g_cs_pair
    assign seq_cs_n[2*p +: 2] = cs_act ? CS_PAIR_ACTIVE : CS_PAIR_IDLE;
  end

  always_comb begin
    seq_cke   = '1;
    seq_rst_n = 1'b1;
    seq_cmd   = CMD_DES;
    unique case (step_i)
      ST_PREA: seq_cmd = CMD_PREA;
      ST_SRE: begin
        seq_cmd = CMD_SRE;
        seq_cke = '0;
      end
      ST_DONE: begin
        seq_cke   = '0;
        seq_rst_n = 1'b0;
      end
      default: ;
    endcase
  end

  assign mem_cs_n_o    = mux_sel_o ? seq_cs_n  : nrm_cs_n_i;
  assign mem_cke_o     = mux_sel_o ? seq_cke   : nrm_cke_i;
  assign mem_reset_n_o = mux_sel_o ? seq_rst_n : nrm_reset_n_i;
  assign mem_cmd_o     = mux_sel_o ? seq_cmd   : nrm_cmd_i;
endmodule

// File: rtl/pf_sr_seq.sv
module pf_sr_seq #(
  parameter int TRFC_W   = 16,
  parameter int TRP_W    = 8,
  parameter int TCKSRE_W = 8,
  parameter int CS_PAIRS = 2,
  parameter int CKE_W    = 2,
  localparam int CS_W    = 2 * CS_PAIRS,
  localparam int W_A     = (TRFC_W > TRP_W) ? TRFC_W : TRP_W,
  localparam int DATA_W  = (W_A > TCKSRE_W) ? W_A : TCKSRE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [DATA_W-1:0]  cfg_data_i,
  input  logic               trigger_i,
  input  logic [CS_W-1:0]    nrm_cs_n_i,
  input  logic [CKE_W-1:0]   nrm_cke_i,
  input  logic               nrm_reset_n_i,
  input  logic [1:0]         nrm_cmd_i,
  output logic [CS_W-1:0]    mem_cs_n_o,
  output logic [CKE_W-1:0]   mem_cke_o,
  output logic               mem_reset_n_o,
  output logic [1:0]         mem_cmd_o,
  output logic               mux_sel_o,
  output logic               done_o
);
  import pf_sr_pkg::*;

  logic [TRFC_W-1:0]   cfg_trfc;
  logic [TRP_W-1:0]    cfg_trp;
  logic [TCKSRE_W-1:0] cfg_tcksre;
  step_e               step;

  pf_sr_cfg #(
    .TRFC_W(TRFC_W), .TRP_W(TRP_W), .TCKSRE_W(TCKSRE_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .idle_i   (step == ST_IDLE),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .data_i   (cfg_data_i),
    .trfc_o   (cfg_trfc),
    .trp_o    (cfg_trp),
    .tcksre_o (cfg_tcksre)
  );

  pf_sr_fsm #(
    .TRFC_W(TRFC_W), .TRP_W(TRP_W), .TCKSRE_W(TCKSRE_W), .CNT_W(DATA_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .trigger_i (trigger_i),
    .trfc_i    (cfg_trfc),
    .trp_i     (cfg_trp),
    .tcksre_i  (cfg_tcksre),
    .step_o    (step)
  );

  pf_sr_pinmux #(.CS_PAIRS(CS_PAIRS), .CKE_W(CKE_W)) u_mux (
    .step_i        (step),
    .nrm_cs_n_i, .nrm_cke_i, .nrm_reset_n_i, .nrm_cmd_i,
    .mem_cs_n_o, .mem_cke_o, .mem_reset_n_o, .mem_cmd_o,
    .mux_sel_o, .done_o
  );
endmodule

// File: rtl/pf_sr_seq_chk.sv
module pf_sr_seq_chk #(
  parameter int TRFC_W   = 16,
  parameter int TRP_W    = 8,
  parameter int TCKSRE_W = 8,
  parameter int CS_PAIRS = 2,
  parameter int CKE_W    = 2,
  localparam int CS_W    = 2 * CS_PAIRS
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                trigger_i,
  input logic [CS_W-1:0]     nrm_cs_n_i,
  input logic [CKE_W-1:0]    nrm_cke_i,
  input logic                nrm_reset_n_i,
  input logic [1:0]          nrm_cmd_i,
  input logic [CS_W-1:0]     mem_cs_n_o,
  input logic [CKE_W-1:0]    mem_cke_o,
  input logic                mem_reset_n_o,
  input logic [1:0]          mem_cmd_o,
  input logic                mux_sel_o,
  input logic                done_o,
  input logic [TRFC_W-1:0]   cfg_trfc,
  input logic [TRP_W-1:0]    cfg_trp,
  input logic [TCKSRE_W-1:0] cfg_tcksre
);
  assert_idle_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mux_sel_o |-> (mem_cs_n_o == nrm_cs_n_i && mem_cke_o == nrm_cke_i &&
                    mem_reset_n_o == nrm_reset_n_i && mem_cmd_o == nrm_cmd_i));

  assert_start_des_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mux_sel_o && trigger_i) |=> (mux_sel_o && mem_cmd_o == 2'b00 &&
                                   (&mem_cs_n_o) && (&mem_cke_o) && mem_reset_n_o));

  assert_prea_pins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o && mem_cmd_o == 2'b01) |-> (mem_cs_n_o == '0 && (&mem_cke_o) && mem_reset_n_o));

  assert_prea_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o && mem_cmd_o == 2'b01 && $past(mem_cmd_o) != 2'b01) |->
      ($past(mux_sel_o) && $past(mem_cmd_o) == 2'b00));

  assert_sre_pins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o && mem_cmd_o == 2'b10) |-> (mem_cs_n_o == '0 && mem_cke_o == '0 && mem_reset_n_o));

  assert_done_pins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mux_sel_o && !mem_reset_n_o && mem_cke_o == '0 && (&mem_cs_n_o) && mem_cmd_o == 2'b00));

  assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  assert_cfg_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mux_sel_o) |-> ($stable(cfg_trfc) && $stable(cfg_trp) && $stable(cfg_tcksre)));

  assert_sel_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_sel_o |=> mux_sel_o);

  assert_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && trigger_i) |=> (done_o && !mem_reset_n_o));
endmodule

bind pf_sr_seq pf_sr_seq_chk #(
  .TRFC_W(TRFC_W), .TRP_W(TRP_W), .TCKSRE_W(TCKSRE_W),
  .CS_PAIRS(CS_PAIRS), .CKE_W(CKE_W)
) u_chk (
  .clk_i, .rst_ni, .trigger_i,
  .nrm_cs_n_i, .nrm_cke_i, .nrm_reset_n_i, .nrm_cmd_i,
  .mem_cs_n_o, .mem_cke_o, .mem_reset_n_o, .mem_cmd_o,
  .mux_sel_o, .done_o,
  .cfg_trfc, .cfg_trp, .cfg_tcksre
);

// File: tb/pf_sr_seq_tb.sv
module pf_sr_seq_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] cs;
    logic [1:0] cke;
    logic       rst;
    logic [1:0] cmd;
    logic       sel;
    logic       done;
  } pins_t;

  localparam pins_t P_DES  = '{cs: 4'hF, cke: 2'b11, rst: 1'b1, cmd: 2'b00, sel: 1'b1, done: 1'b0};
  localparam pins_t P_PREA = '{cs: 4'h0, cke: 2'b11, rst: 1'b1, cmd: 2'b01, sel: 1'b1, done: 1'b0};
  localparam pins_t P_SRE  = '{cs: 4'h0, cke: 2'b00, rst: 1'b1, cmd: 2'b10, sel: 1'b1, done: 1'b0};
  localparam pins_t P_DONE = '{cs: 4'hF, cke: 2'b00, rst: 1'b0, cmd: 2'b00, sel: 1'b1, done: 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] sel = '0;
  logic [15:0] data = '0;
  logic trig = 1'b0;
  logic [3:0] n_cs = 4'hF;
  logic [1:0] n_cke = 2'b11;
  logic n_rst = 1'b1;
  logic [1:0] n_cmd = 2'b00;
  logic [3:0] cs_o;
  logic [1:0] cke_o;
  logic rst_o;
  logic [1:0] cmd_o;
  logic sel_o, done_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_sr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_sel_i(sel), .cfg_data_i(data),
    .trigger_i(trig), .nrm_cs_n_i(n_cs), .nrm_cke_i(n_cke), .nrm_reset_n_i(n_rst),
    .nrm_cmd_i(n_cmd), .mem_cs_n_o(cs_o), .mem_cke_o(cke_o), .mem_reset_n_o(rst_o),
    .mem_cmd_o(cmd_o), .mux_sel_o(sel_o), .done_o(done_o)
  );

  // reference model
  pins_t q[$];
  pins_t cur;
  bit    run;
  int    sh_trfc, sh_trp, sh_tcksre;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run = 0; q.delete(); cur = P_DONE;
      sh_trfc = 0; sh_trp = 0; sh_tcksre = 0;
    end else begin
      bit was_run;
      was_run = run;
      if (!run && trig) begin
        for (int i = 0; i <= sh_trfc; i++)   q.push_back(P_DES);
        for (int i = 0; i <= sh_trp; i++)    q.push_back(P_PREA);
        for (int i = 0; i <= sh_tcksre; i++) q.push_back(P_SRE);
        run = 1;
      end
      if (!was_run && we) begin
        case (sel)
          2'd0: sh_trfc   = int'(data);
          2'd1: sh_trp    = int'(data[7:0]);
          2'd2: sh_tcksre = int'(data[7:0]);
          default: ;
        endcase
      end
      if (run) cur = (q.size() > 0) ? q.pop_front() : P_DONE;
    end
  end

  function automatic string tag_of(pins_t p);
    if (!p.sel) return "R2";
    if (p.done) return "R6/R10";
    case (p.cmd)
      2'b00: return "R3/R10";
      2'b01: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  int len_run, len_prea;
  always @(negedge clk) begin
    if (rst_n) begin
      pins_t act, exp;
      act = '{cs: cs_o, cke: cke_o, rst: rst_o, cmd: cmd_o, sel: sel_o, done: done_o};
      exp = run ? cur : '{cs: n_cs, cke: n_cke, rst: n_rst, cmd: n_cmd, sel: 1'b0, done: 1'b0};
      check(act == exp, tag_of(exp), int'(act), int'(exp));
      if (sel_o && !done_o) len_run++;
      if (sel_o && cmd_o == 2'b01) len_prea++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    we = 1'b1; sel = s; data = d;
    cyc(1);
    we = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1; cyc(1); trig = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #(CLK_PERIOD * 2);
    @(negedge clk);
    // R1: reset state
    check(sel_o == 1'b0, "R1 mux_sel", sel_o, 0);
    check(done_o == 1'b0, "R1 done", done_o, 0);
    rst_n = 1'b1;
    cyc(1);
    len_run = 0; len_prea = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: idle passthrough with varied normal patterns
    for (int i = 0; i < 20; i++) begin
      n_cs = 4'($urandom); n_cke = 2'($urandom); n_rst = 1'($urandom); n_cmd = 2'($urandom);
      cyc(1);
    end
    // R1: regs reset to zero -> each step one cycle (also R9)
    pulse_trig();
    cyc(8);
    check(len_run == 3, "R1/R9 run length", len_run, 3);
    check(done_o == 1'b1, "R6 done", done_o, 1);

    // main run with retrigger and late write
    do_reset();
    wr(2'd0, 16'd5); wr(2'd1, 16'd3); wr(2'd2, 16'd2);
    wr(2'd3, 16'd7);  // R8: select 3 writes nothing
    pulse_trig();
    cyc(2);
    wr(2'd1, 16'd9);  // R8: discarded, run in progress
    cyc(5);
    pulse_trig();     // R7: ignored mid-run
    cyc(10);
    check(len_prea == 4, "R8 prea length", len_prea, 4);
    check(len_run == 13, "R7 run length", len_run, 13);
    pulse_trig();     // R7: ignored when done
    cyc(3);
    check(rst_o == 1'b0 && done_o, "R7/R6 hold", {rst_o, done_o}, 1);

    // R9 with explicit zeros, R3 long tRFC
    do_reset();
    wr(2'd0, 16'd40); wr(2'd1, 16'd0); wr(2'd2, 16'd12);
    pulse_trig();
    cyc(60);
    check(len_prea == 1, "R9 zero tRP", len_prea, 1);
    check(len_run == 41 + 1 + 13, "R3 run length", len_run, 55);

    // R8: idle write after reset takes effect (tRP 200)
    do_reset();
    wr(2'd1, 16'd200);
    pulse_trig();
    cyc(210);
    check(len_prea == 201, "R8 idle write", len_prea, 201);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule